// File: doc/BRIEF.md
# Gated Period-Match Interval Timer

This block is a 16-bit interval timer that sits on a peripheral register bus. A counter advances on prescaled ticks. On a tick where the counter already holds the period value, it restarts from zero and raises a sticky event flag that can drive an interrupt line. The tick source is set in a control register. It can be the bus clock, or the bus clock gated by an external level. It can also be rising edges of an external input, taken either through a full synchroniser or through a shorter path with lower latency.

Software programs the period, the optional starting count and the control word. It then polls or waits on the flag, and clears the flag by writing a dedicated address. Gated mode measures how long an external signal stays high. The flag also fires when the gate falls, so the accumulated width can be read at that point.

Top module: `intv_timer`

## Requirements
- R1: After reset the control, count, period and flag registers all read zero, and `evt_flag` is low.
- R2: While control bit 15 (enable) is 0, the count does not change unless software writes it.
- R3: With the internal source selected (bit 1 = 0) and gating off, control bits 5:4 set how many bus clocks make one count: 00 gives 1, 01 gives 8, 10 gives 64 and 11 gives 256.
- R4: On a tick where the count equals the period, the count becomes 0 and the flag is set. On any other tick the count goes up by 1.
- R5: With a period of 0 the count stays at 0, and every tick sets the flag.
- R6: The flag stays set until address 3 is written. A write to address 3 clears it, unless a new event sets it in the same cycle; in that case the set wins.
- R7: In gated mode (bit 7 = 1, bit 1 = 0), prescaled bus clocks count only while the synchronised `ext_in` is high. The synchronised level lags the pin by two bus clocks.
- R8: In gated mode, a falling edge of the synchronised `ext_in` sets the flag.
- R9: With bit 1 = 1 and bit 2 = 1, each rising edge of `ext_in` makes one prescaler input, two bus clocks after the edge is first sampled.
- R10: With bit 1 = 1 and bit 2 = 0, each rising edge of `ext_in` makes one prescaler input one bus clock earlier than in R9, because the path skips the second synchroniser stage.
- R11: When bit 1 = 1, bit 7 has no effect on counting or on the flag.
- R12: Writing the control register or the count register clears the prescaler.
- R13: The register map is: address 0 control, address 1 count, address 2 period, and address 3 flag in bit 0. Only control bits 15, 7, 5, 4, 2 and 1 are stored, and all other control bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the addressed register (combinational) |
| ext_in | input | 1 | External clock, event or gate input |
| evt_flag | output | 1 | Sticky period-match / gate-end event flag |

## Verification
The bench builds the timer with its default two-stage synchroniser. This makes the two-clock and one-clock latencies of the synchronised and direct external paths exact, so a cycle-accurate model can compare the count and flag on every clock. Small periods such as 0 and 10 bring the wrap and flag corner cases within a few dozen cycles. A full-range period lets the 1:256 prescaler run for several counts without wrapping. Toggling `ext_in` at varied widths covers gate edges, the external edge modes and the ignored gate bit.

// File: rtl/intv_pkg.sv
package intv_pkg;
  localparam int TMR_W = 16;
  localparam int PS_W  = 8;

  localparam int CB_ON   = 15;
  localparam int CB_GATE = 7;
  localparam int CB_PSHI = 5;
  localparam int CB_PSLO = 4;
  localparam int CB_SYNC = 2;
  localparam int CB_SRC  = 1;

  localparam logic [TMR_W-1:0] CTRL_MASK = 16'h80B6;

  typedef enum logic [1:0] {
    ADR_CTRL   = 2'd0,
    ADR_COUNT  = 2'd1,
    ADR_PERIOD = 2'd2,
    ADR_FLAG   = 2'd3
  } reg_adr_e;

  // terminal value of the prescaler for each divide selection
  function automatic logic [PS_W-1:0] ps_limit(input logic [1:0] sel);
    case (sel)
      2'd0:    ps_limit = 8'd0;
      2'd1:    ps_limit = 8'd7;
      2'd2:    ps_limit = 8'd63;
      default: ps_limit = 8'd255;
    endcase
  endfunction
endpackage

// File: rtl/intv_edge_sync.sv
module intv_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic lvl_sync,
  output logic rise_sync,
  output logic fall_sync,
  output logic rise_fast
);
  localparam int LAST = STAGES;

  logic [LAST:0] sh_q;
  logic [LAST:0] sh_d;

  always_comb begin
    sh_d = {sh_q[LAST-1:0], pin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign lvl_sync  = sh_q[LAST-1];
  assign rise_sync = sh_q[LAST-1] & ~sh_q[LAST];
  assign fall_sync = ~sh_q[LAST-1] & sh_q[LAST];

  generate
    if (STAGES >= 2) begin : g_fast
      assign rise_fast = sh_q[0] & ~sh_q[1];
    end else begin : g_same
      assign rise_fast = rise_sync;
    end
  endgenerate

  // R9: the synchronised rise always follows a fast-path rise
  a_r9_sync_lag: assert property (@(posedge clk) disable iff (!rst_n)
    rise_sync |-> $past(rise_fast));
endmodule

// File: rtl/intv_prescale.sv
module intv_prescale
  import intv_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       cin,
  input  logic [1:0] sel,
  output logic       tick
);
  logic [PS_W-1:0] pc_q;
  logic [PS_W-1:0] pc_d;
  logic            at_lim;

  always_comb begin
    at_lim = (pc_q == ps_limit(sel));
    tick   = cin & at_lim;
    pc_d   = pc_q;
    if (clr)       pc_d = '0;
    else if (tick) pc_d = '0;
    else if (cin)  pc_d = pc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end

  // R3: any divide above 1 never yields back-to-back ticks
  a_r3_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && sel != 2'd0 && !clr) |=> !tick);
endmodule

// File: rtl/intv_counter.sv
module intv_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic [W-1:0] per,
  input  logic         ev_extra,
  input  logic         flag_clr,
  output logic [W-1:0] cnt,
  output logic         flag
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         flag_q, flag_d;
  logic         match;

  always_comb begin
    match  = (cnt_q == per);
    cnt_d  = cnt_q;
    if (ld)        cnt_d = ld_val;
    else if (tick) cnt_d = match ? '0 : cnt_q + 1'b1;
    flag_d = flag_q;
    if ((tick && match) || ev_extra) flag_d = 1'b1;
    else if (flag_clr)               flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
    end
  end

  assign cnt  = cnt_q;
  assign flag = flag_q;

  // R4: a tick at the period restarts the count and raises the flag
  a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ld && cnt == per) |=> (cnt == '0 && flag));
  // R6: flag is sticky without a clear
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !flag_clr) |=> flag);
  // R4: without a load the count only holds, steps by one or restarts
  a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
    !ld |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1 || cnt == '0));
endmodule

// File: rtl/intv_timer.sv
module intv_timer
  import intv_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  reg_addr,
  input  logic        reg_wr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  input  logic        ext_in,
  output logic        evt_flag
);
  logic [TMR_W-1:0] ctrl_q, ctrl_d;
  logic [TMR_W-1:0] per_q, per_d;
  logic [TMR_W-1:0] cnt;
  logic             wr_ctrl, wr_cnt, wr_per, wr_flag;
  logic             on, src_ext, sync_on, gate_on, gated;
  logic             lvl_s, rise_s, fall_s, rise_f;
  logic             cin, tick, gate_end;

  always_comb begin
    wr_ctrl = reg_wr && (reg_addr == ADR_CTRL);
    wr_cnt  = reg_wr && (reg_addr == ADR_COUNT);
    wr_per  = reg_wr && (reg_addr == ADR_PERIOD);
    wr_flag = reg_wr && (reg_addr == ADR_FLAG);
    ctrl_d  = wr_ctrl ? (reg_wdata & CTRL_MASK) : ctrl_q;
    per_d   = wr_per ? reg_wdata : per_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      per_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      per_q  <= per_d;
    end
  end

  assign on      = ctrl_q[CB_ON];
  assign src_ext = ctrl_q[CB_SRC];
  assign sync_on = ctrl_q[CB_SYNC];
  assign gate_on = ctrl_q[CB_GATE];
  assign gated   = on && !src_ext && gate_on;

  intv_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(ext_in),
    .lvl_sync(lvl_s), .rise_sync(rise_s), .fall_sync(fall_s), .rise_fast(rise_f)
  );

  always_comb begin
    if (!on)          cin = 1'b0;
    else if (src_ext) cin = sync_on ? rise_s : rise_f;
    else if (gate_on) cin = lvl_s;
    else              cin = 1'b1;
    gate_end = gated && fall_s;
  end

  intv_prescale u_ps (
    .clk(clk), .rst_n(rst_n), .clr(wr_ctrl || wr_cnt), .cin(cin),
    .sel(ctrl_q[CB_PSHI:CB_PSLO]), .tick(tick)
  );

  intv_counter #(.W(TMR_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ld(wr_cnt), .ld_val(reg_wdata),
    .per(per_q), .ev_extra(gate_end), .flag_clr(wr_flag),
    .cnt(cnt), .flag(evt_flag)
  );

  always_comb begin
    case (reg_addr)
      ADR_CTRL:   reg_rdata = ctrl_q;
      ADR_COUNT:  reg_rdata = cnt;
      ADR_PERIOD: reg_rdata = per_q;
      default:    reg_rdata = {{(TMR_W-1){1'b0}}, evt_flag};
    endcase
  end

  // R2: a disabled timer keeps its count unless software loads it
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!on && !wr_cnt) |=> $stable(cnt));
  // R8: gate falling edge in gated mode raises the flag
  a_r8_gate_end: assert property (@(posedge clk) disable iff (!rst_n)
    (gated && fall_s) |=> evt_flag);
  // R13: unstored control bits always read zero
  a_r13_ctrl_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q & ~CTRL_MASK) == '0);
endmodule

// File: tb/sim_intv_timer.sv
module sim_intv_timer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  reg_addr;
  logic        reg_wr;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic        ext_in;
  logic        evt_flag;

  always #5 clk = ~clk;

  intv_timer u0 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_in(ext_in),
    .evt_flag(evt_flag)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  string cur_req = "R1";

  // behavioural reference
  int m_ctrl, m_cnt, m_per, m_flag, m_pc, m_s1, m_s2, m_s3;

  function automatic int lim_of(int sel);
    case (sel)
      0: return 0;
      1: return 7;
      2: return 63;
      default: return 255;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = 0; m_cnt = 0; m_per = 0; m_flag = 0; m_pc = 0;
      m_s1 = 0; m_s2 = 0; m_s3 = 0;
    end else begin
      int cin, tick, on, src, gt, setf, a, w;
      a  = int'(reg_addr);
      w  = reg_wr ? 1 : 0;
      on = (m_ctrl >> 15) & 1;
      src = (m_ctrl >> 1) & 1;
      gt = (m_ctrl >> 7) & 1;
      if (!on) cin = 0;
      else if (src) cin = ((m_ctrl >> 2) & 1) ? (m_s2 & ~m_s3 & 1) : (m_s1 & ~m_s2 & 1);
      else if (gt) cin = m_s2;
      else cin = 1;
      tick = cin && (m_pc == lim_of((m_ctrl >> 4) & 3));
      setf = (tick && m_cnt == m_per) || (on && !src && gt && !m_s2 && m_s3);
      if (w && (a == 0 || a == 1)) m_pc = 0;
      else if (tick) m_pc = 0;
      else if (cin) m_pc = m_pc + 1;
      if (setf) m_flag = 1;
      else if (w && a == 3) m_flag = 0;
      if (w && a == 1) m_cnt = int'(reg_wdata);
      else if (tick) m_cnt = (m_cnt == m_per) ? 0 : (m_cnt + 1) & 16'hFFFF;
      if (w && a == 2) m_per = int'(reg_wdata);
      if (w && a == 0) m_ctrl = int'(reg_wdata) & 16'h80B6;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_in ? 1 : 0;
    end
  end

  function automatic int m_read(int a);
    case (a)
      0: return m_ctrl;
      1: return m_cnt;
      2: return m_per;
      default: return m_flag;
    endcase
  endfunction

  task automatic chk(string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      chk("rdata", int'(reg_rdata), m_read(int'(reg_addr)));
      chk("evt_flag", int'(evt_flag), m_flag);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 2'd1;
  endtask

  task automatic rd(input logic [1:0] a);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    reg_addr = 2'd1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wave(input int reps, input int hi, input int lo);
    for (int k = 0; k < reps; k++) begin
      @(negedge clk); ext_in = 1'b1;
      repeat (hi - 1) @(negedge clk);
      @(negedge clk); ext_in = 1'b0;
      repeat (lo - 1) @(negedge clk);
    end
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_addr = 2'd1; reg_wr = 1'b0; reg_wdata = '0; ext_in = 1'b0;
    idle(3);
    rst_n = 1'b1;
    cur_req = "R1";
    rd(2'd0); rd(2'd2); rd(2'd3); idle(2);

    cur_req = "R13";
    wr(2'd0, 16'h7FFF); rd(2'd0);
    wr(2'd2, 16'h0005); rd(2'd2);

    cur_req = "R2";
    wr(2'd1, 16'h0003); idle(20);

    cur_req = "R3";
    wr(2'd2, 16'hFFFF); wr(2'd1, 16'h0000);
    wr(2'd0, 16'h8000); idle(40);
    wr(2'd0, 16'h8010); idle(100);
    wr(2'd0, 16'h8020); idle(300);
    wr(2'd0, 16'h8030); idle(1100);

    cur_req = "R4";
    wr(2'd0, 16'h0000); wr(2'd2, 16'd10); wr(2'd1, 16'h0000);
    wr(2'd0, 16'h8000); idle(30);
    cur_req = "R6";
    wr(2'd0, 16'h0000); idle(5); rd(2'd3);
    wr(2'd3, 16'h0000); rd(2'd3); idle(3);

    cur_req = "R5";
    wr(2'd2, 16'h0000); wr(2'd1, 16'h0000);
    wr(2'd0, 16'h8000); idle(6);
    wr(2'd3, 16'h0000); idle(2);
    wr(2'd0, 16'h8010); idle(30);

    cur_req = "R7";
    wr(2'd0, 16'h0000); wr(2'd3, 16'h0000);
    wr(2'd2, 16'hFFFF); wr(2'd1, 16'h0000);
    wr(2'd0, 16'h8080);
    idle(5); wave(1, 20, 15);
    cur_req = "R8";
    wave(3, 7, 4); rd(2'd3); wr(2'd3, 16'h0000);
    wr(2'd0, 16'h8090); wave(4, 12, 6);

    cur_req = "R9";
    wr(2'd0, 16'h8006); wave(10, 2, 2); wave(5, 1, 3); wave(4, 3, 1);
    wr(2'd0, 16'h8016); wave(20, 2, 2);

    cur_req = "R10";
    wr(2'd0, 16'h8002); wave(10, 2, 2); wave(5, 1, 3); wave(4, 3, 2);

    cur_req = "R11";
    wr(2'd3, 16'h0000);
    wr(2'd0, 16'h8082); wave(8, 2, 3); wave(2, 10, 10);
    wr(2'd0, 16'h8086); wave(8, 3, 2); wave(2, 10, 10); rd(2'd3);

    cur_req = "R12";
    wr(2'd1, 16'h0000); wr(2'd0, 16'h8010); idle(5);
    wr(2'd0, 16'h8010); idle(5);
    wr(2'd1, 16'h0010); idle(12);
    wr(2'd1, 16'h0020); idle(20);

    summary();
    $finish;
  end
endmodule